// File: doc/BRIEF.md
# Serial-Parallel Bit-Stream Multiplier

This block multiplies two unsigned K-bit numbers. The multiplicand arrives as a parallel word. The multiplier arrives one bit per step, least significant bit first. The full 2K-bit product leaves one bit per step, also least significant bit first. The datapath is a row of K identical cells. Each cell gates its multiplicand bit with the current multiplier bit and adds the result into a one-bit full adder. That adder takes the sum held by its more significant neighbour and its own carry held from the previous step. The cell then stores the new sum and carry. The current multiplier bit reaches every cell over one broadcast net, which has a fan-out of K. The least significant cell's stored sum is the outgoing product bit.

A one-cycle `start` strobe begins a frame. It captures the multiplicand and clears every sum and carry register. The block then takes exactly K multiplier bits from a valid/ready input stream. After those K bits it supplies the K trailing zero steps itself, so the caller never sends padding. The product bits leave on a valid/ready output stream. When the output is stalled (`prod_valid` high and `prod_ready` low), the whole array freezes and `mbit_ready` stays low. When the input is starved (`mbit_valid` low while bits are still needed), the array also waits. A `start` in the middle of a frame abandons that frame and begins a new one.

Top module: `spm_serial_mul`

## Requirements
- R1: While reset is asserted and after its release, `prod_valid` and `mbit_ready` are low until a `start` strobe arrives.
- R2: The multiplicand is sampled only in the cycle `start` is high; changes on `mcand` during the frame do not alter the product.
- R3: After `start`, `mbit_ready` accepts exactly K multiplier bits per frame, taken as bit 0 first, and it is low in the `start` cycle and after the K-th accepted bit.
- R4: The 2K product bits emitted in a frame, with output number n carrying weight 2^n, form the unsigned product of the multiplicand and the multiplier.
- R5: With `mbit_valid` and `prod_ready` held high, the first product bit is valid in the cycle after the first multiplier bit is accepted, `prod_valid` stays high for exactly 2K consecutive cycles, and it is low afterwards.
- R6: While `prod_valid` is high and `prod_ready` is low, `prod_valid` and `prod_bit` hold steady and `mbit_ready` is low.
- R7: `start` clears all sum and carry state and any pending output bit, so `prod_valid` is low in the cycle after it; back-to-back frames and a frame aborted by a new `start` do not affect the next product.
- R8: Gaps in `mbit_valid` and in `prod_ready` delay the stream but do not change the product; `mbit` is ignored while `mbit_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame start strobe; loads multiplicand, clears state |
| mcand | input | K | Parallel multiplicand |
| mbit_valid | input | 1 | Multiplier bit is present |
| mbit_ready | output | 1 | Block takes a multiplier bit this cycle |
| mbit | input | 1 | Serial multiplier bit, LSB first |
| prod_valid | output | 1 | Product bit is present |
| prod_ready | input | 1 | Consumer takes the product bit this cycle |
| prod_bit | output | 1 | Serial product bit, LSB first |

## Verification
A product bit is due one cycle after the step that forms it. A step happens on the edge where an input bit is accepted, or, once K bits are in, on each edge where the output slot is free. So the first output bit is due one cycle after the first input handshake. The bench drives inputs on the falling edge and samples the handshakes one time unit later. It records each transfer in the cycle it occurs and checks the first-output latency, the gap-free 2K run and the low `prod_valid` in the cycle after the last bit. With random stalls it checks the held bit on the cycle after each refused transfer. The product value is rebuilt from the transfers alone.

// File: rtl/spm_pkg.sv
package spm_pkg;
  // bits needed to count from 0 to n-1
  function automatic int ctr_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/spm_cell.sv
module spm_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic pp,
  input  logic s_in,
  output logic s_q
);
  logic       c_q;
  logic [1:0] tot;

  assign tot = {1'b0, pp} + {1'b0, s_in} + {1'b0, c_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= 1'b0;
      c_q <= 1'b0;
    end else if (clr) begin
      s_q <= 1'b0;
      c_q <= 1'b0;
    end else if (en) begin
      s_q <= tot[0];
      c_q <= tot[1];
    end
  end
endmodule

// File: rtl/spm_array.sv
module spm_array #(
  parameter int K = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [K-1:0] mcand,
  input  logic         xbit,
  output logic         lsb
);
  logic [K:0] s_chain;

  assign s_chain[K] = 1'b0;

  for (genvar i = 0; i < K; i++) begin : g_cell
    logic pp;
    assign pp = mcand[i] & xbit;
    spm_cell u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .en   (en),
      .pp   (pp),
      .s_in (s_chain[i+1]),
      .s_q  (s_chain[i])
    );
  end

  assign lsb = s_chain[0];
endmodule

// File: rtl/spm_ctrl.sv
module spm_ctrl #(
  parameter int K = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic mbit_valid,
  input  logic prod_ready,
  output logic mbit_ready,
  output logic prod_valid,
  output logic feeding,
  output logic step
);
  localparam int CW = spm_pkg::ctr_width(2 * K);
  localparam logic [CW-1:0] LAST = CW'(2 * K - 1);
  localparam logic [CW-1:0] HALF = CW'(K);

  logic          busy;
  logic          ov;
  logic [CW-1:0] cnt;
  logic          slot_free;

  assign feeding    = cnt < HALF;
  assign slot_free  = !ov || prod_ready;
  assign step       = busy && !start && slot_free && (!feeding || mbit_valid);
  assign mbit_ready = busy && !start && slot_free && feeding;
  assign prod_valid = ov;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ov   <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      ov   <= 1'b0;
      cnt  <= '0;
    end else if (step) begin
      ov <= 1'b1;
      if (cnt == LAST) busy <= 1'b0;
      else             cnt  <= cnt + 1'b1;
    end else if (prod_ready) begin
      ov <= 1'b0;
    end
  end
endmodule

// File: rtl/spm_serial_mul.sv
module spm_serial_mul #(
  parameter int K = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [K-1:0] mcand,
  input  logic         mbit_valid,
  output logic         mbit_ready,
  input  logic         mbit,
  output logic         prod_valid,
  input  logic         prod_ready,
  output logic         prod_bit
);
  logic [K-1:0] mcand_q;
  logic         feeding;
  logic         step;
  logic         xbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mcand_q <= '0;
    else if (start) mcand_q <= mcand;
  end

  spm_ctrl #(.K(K)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mbit_valid(mbit_valid),
    .prod_ready(prod_ready),
    .mbit_ready(mbit_ready),
    .prod_valid(prod_valid),
    .feeding   (feeding),
    .step      (step)
  );

  // trailing K steps use an internal zero multiplier bit
  assign xbit = feeding ? mbit : 1'b0;

  spm_array #(.K(K)) u_array (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start),
    .en   (step),
    .mcand(mcand_q),
    .xbit (xbit),
    .lsb  (prod_bit)
  );
endmodule

// File: rtl/spm_check.sv
module spm_check #(
  parameter int K = 8
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic mbit_valid,
  input logic mbit_ready,
  input logic prod_valid,
  input logic prod_ready,
  input logic prod_bit
);
  localparam int NW = $clog2(2 * K + 1);

  logic [NW-1:0] n_in;
  logic [NW-1:0] n_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_in  <= '0;
      n_out <= '0;
    end else if (start) begin
      n_in  <= '0;
      n_out <= '0;
    end else begin
      if (mbit_valid && mbit_ready) n_in  <= n_in + 1'b1;
      if (prod_valid && prod_ready) n_out <= n_out + 1'b1;
    end
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (!prod_valid && !mbit_ready));

  assert_in_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mbit_valid && mbit_ready) |-> (n_in < NW'(K)));

  assert_ready_low_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !mbit_ready);

  assert_out_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_valid && prod_ready && !start) |-> (n_out < NW'(2 * K)));

  assert_hold_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_valid && !prod_ready && !start) |=> (prod_valid && $stable(prod_bit)));

  assert_no_take_when_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_valid && !prod_ready) |-> !mbit_ready);

  assert_start_flushes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !prod_valid);
endmodule

bind spm_serial_mul spm_check #(.K(K)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .mbit_valid(mbit_valid),
  .mbit_ready(mbit_ready),
  .prod_valid(prod_valid),
  .prod_ready(prod_ready),
  .prod_bit  (prod_bit)
);

// File: tb/sim_spm_serial_mul.sv
module sim_spm_serial_mul;
  localparam int KB = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [KB-1:0] mcand = '0;
  logic          mbit_valid = 1'b0;
  logic          mbit_ready;
  logic          mbit = 1'b0;
  logic          prod_valid;
  logic          prod_ready = 1'b1;
  logic          prod_bit;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  spm_serial_mul #(.K(KB)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
    .mbit_valid(mbit_valid), .mbit_ready(mbit_ready), .mbit(mbit),
    .prod_valid(prod_valid), .prod_ready(prod_ready), .prod_bit(prod_bit)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input int a);
    @(negedge clk);
    start = 1'b1;
    mcand = KB'(a);
    mbit_valid = 1'b1;
    mbit = 1'b1;
    prod_ready = 1'b1;
    #1;
    chk(!mbit_ready, "R3 ready in start cycle", longint'(mbit_ready), 0);
    @(negedge clk);
  endtask

  // run one frame; in_mode/out_mode: 0 = always, 1 = random gaps
  task automatic run_frame(input int a, input int x, input int in_mode,
                           input int out_mode, input bit garble);
    int in_i = 0;
    int out_i = 0;
    int cyc = 0;
    int first_in = -1;
    int first_out = -1;
    int last_out = -1;
    bit gap = 0;
    bit held = 0;
    bit held_bit = 0;
    bit extra_ready = 0;
    bit stall_take = 0;
    bit hold_bad = 0;
    longint res = 0;
    pulse_start(a);
    while (out_i < 2 * KB && cyc < 400) begin
      start = 1'b0;
      mcand = garble ? KB'($urandom) : KB'(a);
      mbit_valid = (in_mode == 0) ? (in_i < KB) : ($urandom % 2 == 1);
      mbit = (mbit_valid && in_i < KB) ? x[in_i] : 1'($urandom);
      prod_ready = (out_mode == 0) ? 1'b1 : ($urandom % 2 == 1);
      #1;
      if (held && !(prod_valid && prod_bit == held_bit)) hold_bad = 1;
      held = prod_valid && !prod_ready;
      held_bit = prod_bit;
      if (prod_valid && !prod_ready && mbit_ready) stall_take = 1;
      if (mbit_ready && in_i >= KB) extra_ready = 1;
      if (mbit_valid && mbit_ready) begin
        if (first_in < 0) first_in = cyc;
        in_i++;
      end
      if (prod_valid && prod_ready) begin
        if (first_out < 0) first_out = cyc;
        if (last_out >= 0 && cyc != last_out + 1) gap = 1;
        last_out = cyc;
        res = res | (longint'(prod_bit) << out_i);
        out_i++;
      end
      cyc++;
      @(negedge clk);
    end
    chk(res == longint'(a) * longint'(x), "R4 product", res, longint'(a) * longint'(x));
    chk(in_i == KB && !extra_ready, "R3 accepted bit count", in_i, KB);
    if (out_mode == 1) begin
      chk(!hold_bad, "R6 held output", hold_bad, 0);
      chk(!stall_take, "R6 input blocked while stalled", stall_take, 0);
    end
    if (in_mode == 0 && out_mode == 0) begin
      chk(first_out == first_in + 1, "R5 first bit latency", first_out - first_in, 1);
      chk(!gap, "R5 contiguous valid", gap, 0);
    end
    mbit_valid = 1'b0;
    prod_ready = 1'b1;
    #1;
    chk(!prod_valid, "R5 valid low after frame", prod_valid, 0);
  endtask

  task automatic abort_frame(input int a, input int x, input int n);
    pulse_start(a);
    for (int i = 0; i < n; i++) begin
      start = 1'b0;
      mbit_valid = 1'b1;
      mbit = x[i];
      prod_ready = 1'b1;
      @(negedge clk);
    end
    mbit_valid = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        chk(0, "watchdog", cycles, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!prod_valid && !mbit_ready, "R1 idle in reset", {prod_valid, mbit_ready}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!prod_valid && !mbit_ready, "R1 idle after reset", {prod_valid, mbit_ready}, 0);

    // R4 R5: full sweep, no stalls
    for (int a = 0; a < (1 << KB); a++)
      for (int x = 0; x < (1 << KB); x++)
        run_frame(a, x, 0, 0, 0);

    // R2 R8: multiplicand garbled mid-frame, random gaps on both streams
    for (int a = 0; a < (1 << KB); a++)
      for (int x = 0; x < (1 << KB); x++)
        run_frame(a, x, 1, 1, 1);

    // R7: aborted frames followed by a fresh one
    for (int i = 0; i < 40; i++) begin
      abort_frame(15, 15, (i % (2 * KB)) + 1);
      start = 1'b1;
      #1;
      start = 1'b0;
      run_frame(i % 16, (i * 7) % 16, 0, 0, 0);
    end
    abort_frame(15, 15, 2 * KB);
    run_frame(9, 13, 0, 0, 0);
    run_frame(15, 15, 0, 0, 0);
    run_frame(1, 15, 1, 0, 0);
    run_frame(15, 1, 0, 1, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule